// File: doc/BRIEF.md
# Card Command Response Engine

This block is the command side of a memory-card host model. A start pulse hands it a command word and a 32-bit argument. It takes the opcode from the command word and builds a canned four-word response for that opcode. It then reports completion through one-cycle event pulses. Status-style replies carry a card-state field, a ready-for-data bit and an application-command bit in response word 0. The card-specific register image for the capacity query is taken from a separate encoder on an input bus.

Block read and block write commands also drive a data mover. The engine works out a starting sector from the argument: a high-capacity card passes a block number, and any other card passes a byte offset that is scaled down by the block length. It then issues one request per 512-byte sector over a valid/ready handshake and waits for a done strobe from the mover before issuing the next request. Each request advances the sector number by one and the memory address by 512. The mover does the actual data movement and holds the card storage.

Top module: `card_cmd_engine`

## Requirements
- R1: The opcode is `cmd_word[5:0]`; bits 31:6 of the command word have no effect on any output.
- R2: Every accepted command first clears all four response words. An opcode with no canned reply (for example 63) leaves all four words at zero, even if the previous command had filled them.
- R3: Status replies put the card state in bits 12:9 of response word 0, ready-for-data in bit 8 and application-command in bit 5. Select (7) gives 0x700 and stop (12) gives 0xB00. Status (13), set-length (16), reads (17, 18) and writes (24, 25) give 0x900. Application-prefix (55), switch (6) and SCR fetch (51) give 0x920.
- R4: Opcode 41 returns 0x80FF8000 in word 0. Opcode 8 echoes the argument in word 0. Opcode 9 copies `csd_bits` into the response, with word 3 taken from bits 127:96 and word 0 from bits 31:0.
- R5: Every command pulses `cmd_done` for one cycle. For a command with no transfer, the pulse is high in the second cycle after the start edge. `data_done` pulses with it for reads, writes, opcode 51, and opcode 6 when the argument is 0x00FFFFF1 or 0x80FFFFF1. Opcode 6 with any other argument gives no `data_done`.
- R6: The starting sector is the argument when `high_cap`=1. Otherwise it is the argument shifted right by `blk_len_log2`.
- R7: Opcodes 17 and 24 move exactly one sector whatever `blk_count` holds. Opcodes 18 and 25 move `blk_count` sectors. A count of zero issues no request and completes like a command with no transfer. `xfer_write` is 1 for opcodes 24 and 25 and 0 for opcodes 17 and 18.
- R8: A request holds `xfer_valid`, `xfer_sector` and `xfer_addr` steady until `xfer_ready`. The next request appears in the cycle after the `xfer_done` strobe, with sector +1 and address +512. The first address is `buf_addr`.
- R9: `busy` is high from the start edge until the cycle in which `cmd_done` pulses, and it is low in that cycle. The done pulses follow the last sector's `xfer_done` by one edge. A start pulse that arrives while `busy` is high is ignored.
- R10: A read or write on a card that is not high-capacity, with an argument whose low 9 bits are nonzero, sets `misalign`. The transfer still runs. Only reset clears `misalign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command start pulse |
| cmd_word | input | 32 | Command word, opcode in bits 5:0 |
| cmd_arg | input | 32 | Command argument |
| buf_addr | input | AW | Memory address of the first sector |
| blk_count | input | CW | Sector count for multi-sector commands |
| blk_len_log2 | input | 5 | log2 of the block length for byte-offset cards |
| high_cap | input | 1 | Card takes block numbers rather than byte offsets |
| csd_bits | input | 128 | Register image from the capacity encoder |
| busy | output | 1 | Command in progress |
| cmd_done | output | 1 | Command-complete pulse |
| data_done | output | 1 | Data-complete pulse |
| misalign | output | 1 | Sticky unaligned byte offset flag |
| resp_word0 | output | 32 | Response word 0 |
| resp_word1 | output | 32 | Response word 1 |
| resp_word2 | output | 32 | Response word 2 |
| resp_word3 | output | 32 | Response word 3 |
| xfer_valid | output | 1 | Sector request valid |
| xfer_ready | input | 1 | Mover accepts the request |
| xfer_write | output | 1 | 1 = write to card, 0 = read |
| xfer_sector | output | 32 | Sector number of the request |
| xfer_addr | output | AW | Memory address of the request |
| xfer_done | input | 1 | Mover finished the current sector |

## Verification
A command with no transfer is checked at two falling edges after the start edge. At the first, `busy` must be high and `cmd_done` low. At the second, the responses, `cmd_done`, `data_done` and a low `busy` must all be present. A third edge confirms that the pulses lasted only one cycle. For a transfer, the first request is due one edge after start. Each later request is due one edge after the `xfer_done` strobe, and the done pulses are due one edge after the final strobe. The bench drives the mover itself with varied ready and done delays, and it samples every one of those points on the falling edge, half a cycle after the register that produces the value.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;

  localparam int unsigned DW = 32;

  localparam logic [5:0] OP_SWITCH  = 6'd6;
  localparam logic [5:0] OP_SELECT  = 6'd7;
  localparam logic [5:0] OP_EXT_CSD = 6'd8;
  localparam logic [5:0] OP_CSD     = 6'd9;
  localparam logic [5:0] OP_STOP    = 6'd12;
  localparam logic [5:0] OP_STATUS  = 6'd13;
  localparam logic [5:0] OP_BLKLEN  = 6'd16;
  localparam logic [5:0] OP_RD_ONE  = 6'd17;
  localparam logic [5:0] OP_RD_MANY = 6'd18;
  localparam logic [5:0] OP_WR_ONE  = 6'd24;
  localparam logic [5:0] OP_WR_MANY = 6'd25;
  localparam logic [5:0] OP_OPCOND  = 6'd41;
  localparam logic [5:0] OP_SCR     = 6'd51;
  localparam logic [5:0] OP_APP     = 6'd55;

  localparam logic [DW-1:0] OPCOND_REPLY = 32'h80FF_8000;
  localparam logic [DW-1:0] SWITCH_QRY_A = 32'h00FF_FFF1;
  localparam logic [DW-1:0] SWITCH_QRY_B = 32'h80FF_FFF1;

  typedef enum logic [1:0] {XK_NONE, XK_SINGLE, XK_MULTI} xfer_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FIN, ST_XFER} eng_state_e;

  // status word: state in 12:9, ready-for-data in 8, app flag in 5
  function automatic logic [DW-1:0] status_word(input logic [3:0] st, input logic app);
    status_word = (DW'(st) << 9) | DW'(32'h100) | (app ? DW'(32'h20) : DW'(0));
  endfunction

endpackage

// File: rtl/card_resp_decode.sv
module card_resp_decode
  import card_cmd_pkg::*;
(
  input  logic [5:0]          opcode,
  input  logic [DW-1:0]       arg,
  input  logic [4*DW-1:0]     csd,
  output logic [3:0][DW-1:0]  resp,
  output logic                data_evt,
  output xfer_kind_e          kind,
  output logic                is_write
);

  always_comb begin
    resp     = '0;
    data_evt = 1'b0;
    kind     = XK_NONE;
    is_write = 1'b0;
    unique case (opcode)
      OP_SELECT:  resp[0] = status_word(4'd3, 1'b0);
      OP_STOP:    resp[0] = status_word(4'd5, 1'b0);
      OP_STATUS,
      OP_BLKLEN:  resp[0] = status_word(4'd4, 1'b0);
      OP_APP:     resp[0] = status_word(4'd4, 1'b1);
      OP_SWITCH: begin
        resp[0]  = status_word(4'd4, 1'b1);
        data_evt = (arg == SWITCH_QRY_A) || (arg == SWITCH_QRY_B);
      end
      OP_SCR: begin
        resp[0]  = status_word(4'd4, 1'b1);
        data_evt = 1'b1;
      end
      OP_OPCOND:  resp[0] = OPCOND_REPLY;
      OP_EXT_CSD: resp[0] = arg;
      OP_CSD:     resp    = csd;
      OP_RD_ONE, OP_RD_MANY, OP_WR_ONE, OP_WR_MANY: begin
        resp[0]  = status_word(4'd4, 1'b0);
        data_evt = 1'b1;
        kind     = (opcode == OP_RD_ONE || opcode == OP_WR_ONE) ? XK_SINGLE : XK_MULTI;
        is_write = (opcode == OP_WR_ONE || opcode == OP_WR_MANY);
      end
      default: resp = '0;
    endcase
  end

endmodule

// File: rtl/card_sector_seq.sv
module card_sector_seq #(
  parameter int unsigned AW           = 32,
  parameter int unsigned SW           = 32,
  parameter int unsigned CW           = 32,
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [SW-1:0] first_sector,
  input  logic [AW-1:0] first_addr,
  input  logic [CW-1:0] count,
  input  logic          xfer_ready,
  input  logic          xfer_done,
  output logic          xfer_valid,
  output logic [SW-1:0] xfer_sector,
  output logic [AW-1:0] xfer_addr,
  output logic          last_done
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(SECTOR_BYTES);

  logic          valid_q;
  logic          waiting_q;
  logic [CW-1:0] remain_q;
  logic [SW-1:0] sector_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      waiting_q <= 1'b0;
      remain_q  <= '0;
      sector_q  <= '0;
      addr_q    <= '0;
    end else if (go) begin
      valid_q   <= 1'b1;
      waiting_q <= 1'b0;
      remain_q  <= count;
      sector_q  <= first_sector;
      addr_q    <= first_addr;
    end else if (valid_q && xfer_ready) begin
      valid_q   <= 1'b0;
      waiting_q <= 1'b1;
    end else if (waiting_q && xfer_done) begin
      waiting_q <= 1'b0;
      if (remain_q != CW'(1)) begin
        remain_q <= remain_q - CW'(1);
        sector_q <= sector_q + SW'(1);
        addr_q   <= addr_q + ADDR_STEP;
        valid_q  <= 1'b1;
      end
    end
  end

  assign xfer_valid  = valid_q;
  assign xfer_sector = sector_q;
  assign xfer_addr   = addr_q;
  assign last_done   = waiting_q && xfer_done && (remain_q == CW'(1));

  // R8: a pending request keeps its fields until the mover takes it
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready && !go) |=> (xfer_valid && $stable(xfer_sector) && $stable(xfer_addr)));

  // R8: each follow-on request is one sector and one sector-size further on
  p_req_step_r8: assert property (@(posedge clk) disable iff (rst)
    (waiting_q && xfer_done && !last_done && !go) |=>
      (xfer_valid && xfer_sector == $past(xfer_sector) + SW'(1)
       && xfer_addr == $past(xfer_addr) + ADDR_STEP));

endmodule

// File: rtl/card_cmd_engine.sv
module card_cmd_engine
  import card_cmd_pkg::*;
#(
  parameter int unsigned AW           = 32,
  parameter int unsigned CW           = 32,
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   cmd_word,
  input  logic [31:0]   cmd_arg,
  input  logic [AW-1:0] buf_addr,
  input  logic [CW-1:0] blk_count,
  input  logic [4:0]    blk_len_log2,
  input  logic          high_cap,
  input  logic [127:0]  csd_bits,
  output logic          busy,
  output logic          cmd_done,
  output logic          data_done,
  output logic          misalign,
  output logic [31:0]   resp_word0,
  output logic [31:0]   resp_word1,
  output logic [31:0]   resp_word2,
  output logic [31:0]   resp_word3,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic          xfer_write,
  output logic [31:0]   xfer_sector,
  output logic [AW-1:0] xfer_addr,
  input  logic          xfer_done
);

  localparam int unsigned SEC_LG = $clog2(SECTOR_BYTES);

  logic [3:0][DW-1:0] dec_resp;
  logic               dec_data;
  xfer_kind_e         dec_kind;
  logic               dec_wr;

  logic               unused_cmd_hi;
  assign unused_cmd_hi = ^cmd_word[31:6];

  card_resp_decode i_dec (
    .opcode   (cmd_word[5:0]),
    .arg      (cmd_arg),
    .csd      (csd_bits),
    .resp     (dec_resp),
    .data_evt (dec_data),
    .kind     (dec_kind),
    .is_write (dec_wr)
  );

  eng_state_e         state_q;
  logic [3:0][DW-1:0] resp_q;
  logic               busy_q, cdone_q, ddone_q, dpend_q, wr_q, mis_q;

  logic          accept, xfer_go, seq_last, bad_offset;
  logic [CW-1:0] eff_count;
  logic [DW-1:0] start_sector;

  always_comb begin
    accept       = start && (state_q == ST_IDLE);
    eff_count    = (dec_kind == XK_SINGLE) ? CW'(1) : blk_count;
    xfer_go      = accept && (dec_kind != XK_NONE) && (eff_count != '0);
    start_sector = high_cap ? cmd_arg : (cmd_arg >> blk_len_log2);
    bad_offset   = (dec_kind != XK_NONE) && !high_cap && (cmd_arg[SEC_LG-1:0] != '0);
  end

  card_sector_seq #(
    .AW (AW), .SW (DW), .CW (CW), .SECTOR_BYTES (SECTOR_BYTES)
  ) i_seq (
    .clk          (clk),
    .rst          (rst),
    .go           (xfer_go),
    .first_sector (start_sector),
    .first_addr   (buf_addr),
    .count        (eff_count),
    .xfer_ready   (xfer_ready),
    .xfer_done    (xfer_done),
    .xfer_valid   (xfer_valid),
    .xfer_sector  (xfer_sector),
    .xfer_addr    (xfer_addr),
    .last_done    (seq_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      resp_q  <= '0;
      busy_q  <= 1'b0;
      cdone_q <= 1'b0;
      ddone_q <= 1'b0;
      dpend_q <= 1'b0;
      wr_q    <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      cdone_q <= 1'b0;
      ddone_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          resp_q  <= dec_resp;
          dpend_q <= dec_data;
          wr_q    <= dec_wr;
          busy_q  <= 1'b1;
          if (bad_offset) mis_q <= 1'b1;
          state_q <= xfer_go ? ST_XFER : ST_FIN;
        end
        ST_FIN: begin
          cdone_q <= 1'b1;
          ddone_q <= dpend_q;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        ST_XFER: if (seq_last) begin
          cdone_q <= 1'b1;
          ddone_q <= dpend_q;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign cmd_done   = cdone_q;
  assign data_done  = ddone_q;
  assign misalign   = mis_q;
  assign xfer_write = wr_q;
  assign resp_word0 = resp_q[0];
  assign resp_word1 = resp_q[1];
  assign resp_word2 = resp_q[2];
  assign resp_word3 = resp_q[3];

  // R9: completion is reported only once busy has dropped
  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> !busy);

  // R9: responses do not move while a command is in flight
  p_resp_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(resp_word0) && $stable(resp_word3)));

  // R9: a sector request only exists inside a busy window
  p_req_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> busy);

  // R5: data completion never comes without command completion
  p_data_with_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    data_done |-> cmd_done);

  // R5: the completion strobe lasts a single cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);

  // R10: the misalignment flag never clears outside reset
  p_misalign_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    misalign |=> misalign);

endmodule

// File: tb/test_card_cmd_engine.sv
`timescale 1ns/1ps
module test_card_cmd_engine;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  cmd_word = '0;
  logic [31:0]  cmd_arg = '0;
  logic [31:0]  buf_addr = '0;
  logic [31:0]  blk_count = '0;
  logic [4:0]   blk_len_log2 = 5'd9;
  logic         high_cap = 1'b0;
  logic [127:0] csd_bits = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
  logic         busy, cmd_done, data_done, misalign;
  logic [31:0]  resp_word0, resp_word1, resp_word2, resp_word3;
  logic         xfer_valid, xfer_write;
  logic         xfer_ready = 1'b0;
  logic         xfer_done = 1'b0;
  logic [31:0]  xfer_sector, xfer_addr;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  card_cmd_engine i_card_cmd_engine (
    .clk (clk), .rst (rst), .start (start), .cmd_word (cmd_word), .cmd_arg (cmd_arg),
    .buf_addr (buf_addr), .blk_count (blk_count), .blk_len_log2 (blk_len_log2),
    .high_cap (high_cap), .csd_bits (csd_bits), .busy (busy), .cmd_done (cmd_done),
    .data_done (data_done), .misalign (misalign), .resp_word0 (resp_word0),
    .resp_word1 (resp_word1), .resp_word2 (resp_word2), .resp_word3 (resp_word3),
    .xfer_valid (xfer_valid), .xfer_ready (xfer_ready), .xfer_write (xfer_write),
    .xfer_sector (xfer_sector), .xfer_addr (xfer_addr), .xfer_done (xfer_done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // every-clock invariant from R9: done pulse never coincides with busy
  always @(negedge clk) begin
    if (!rst && cmd_done && busy) begin
      checks++;
      errs++;
      $display("FAIL R9 done-while-busy actual=1 expected=0");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      errs++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  // command with no transfer: done pulse two falling edges after start is raised
  task automatic plain(input string req, input logic [31:0] word, input logic [31:0] arg,
                       input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2,
                       input logic [31:0] e3, input logic edata);
    cmd_word = word;
    cmd_arg  = arg;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", {req, " busy after start"}, {31'd0, busy}, 32'd1);
    chk("R5", {req, " no early done"}, {31'd0, cmd_done}, 32'd0);
    @(negedge clk);
    chk("R5", {req, " cmd_done"}, {31'd0, cmd_done}, 32'd1);
    chk("R5", {req, " data_done"}, {31'd0, data_done}, {31'd0, edata});
    chk("R9", {req, " busy cleared"}, {31'd0, busy}, 32'd0);
    chk(req, "resp0", resp_word0, e0);
    chk(req, "resp1", resp_word1, e1);
    chk(req, "resp2", resp_word2, e2);
    chk(req, "resp3", resp_word3, e3);
    @(negedge clk);
    chk("R5", {req, " pulse ends"}, {31'd0, cmd_done}, 32'd0);
  endtask

  // transfer command with a behavioural mover
  task automatic xfer(input string req, input logic [5:0] op, input logic [31:0] arg,
                      input logic hc, input logic [4:0] lg, input logic [31:0] cnt,
                      input logic [31:0] base, input int n, input logic [31:0] sec0,
                      input logic wr, input bit poke);
    cmd_word = {26'h2AA_AAAA, op};
    cmd_arg = arg; high_cap = hc; blk_len_log2 = lg; blk_count = cnt; buf_addr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", {req, " busy"}, {31'd0, busy}, 32'd1);
    if (n == 0) begin
      chk("R7", {req, " no request"}, {31'd0, xfer_valid}, 32'd0);
      @(negedge clk);
      chk("R7", {req, " zero-count done"}, {30'd0, cmd_done, data_done}, 32'd3);
    end else begin
      for (int i = 0; i < n; i++) begin
        chk("R8", {req, " valid"}, {31'd0, xfer_valid}, 32'd1);
        chk("R6", {req, " sector"}, xfer_sector, sec0 + 32'(i));
        chk("R8", {req, " addr"}, xfer_addr, base + 32'(512 * i));
        chk("R7", {req, " direction"}, {31'd0, xfer_write}, {31'd0, wr});
        for (int d = 0; d < (i % 3); d++) begin
          @(negedge clk);
          chk("R8", {req, " held"}, {31'd0, xfer_valid}, 32'd1);
          chk("R8", {req, " held sector"}, xfer_sector, sec0 + 32'(i));
        end
        xfer_ready = 1'b1;
        @(negedge clk);
        xfer_ready = 1'b0;
        chk("R8", {req, " taken"}, {31'd0, xfer_valid}, 32'd0);
        if (poke && i == 0) begin
          cmd_word = {26'd0, 6'd41};
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
        @(negedge clk);
        chk("R9", {req, " busy in sector"}, {31'd0, busy}, 32'd1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        if (i == n - 1) begin
          chk("R9", {req, " done after last"}, {30'd0, cmd_done, busy}, 32'd2);
          chk("R5", {req, " data_done"}, {31'd0, data_done}, 32'd1);
          chk("R3", {req, " resp0"}, resp_word0, 32'h900);
        end else begin
          chk("R7", {req, " no early done"}, {31'd0, cmd_done}, 32'd0);
        end
      end
    end
    @(negedge clk);
    chk("R5", {req, " pulse ends"}, {31'd0, cmd_done}, 32'd0);
    chk("R8", {req, " no stray request"}, {31'd0, xfer_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9", "reset busy", {31'd0, busy}, 32'd0);
    chk("R2", "reset resp0", resp_word0, 32'd0);
    chk("R10", "reset misalign", {31'd0, misalign}, 32'd0);
    chk("R8", "reset valid", {31'd0, xfer_valid}, 32'd0);

    plain("R1", 32'hFFFF_FFC0 | 32'd13, 32'd0, 32'h900, 0, 0, 0, 1'b0);
    plain("R3", 32'd7, 32'd0, 32'h700, 0, 0, 0, 1'b0);
    plain("R3", 32'd12, 32'd0, 32'hB00, 0, 0, 0, 1'b0);
    plain("R3", 32'd55, 32'd0, 32'h920, 0, 0, 0, 1'b0);
    plain("R3", 32'd16, 32'd77, 32'h900, 0, 0, 0, 1'b0);
    plain("R4", 32'd41, 32'd0, 32'h80FF_8000, 0, 0, 0, 1'b0);
    plain("R4", 32'd8, 32'h1234_5678, 32'h1234_5678, 0, 0, 0, 1'b0);
    plain("R4", 32'd9, 32'd0, 32'h7777_8888, 32'h5555_6666, 32'h3333_4444, 32'h1111_2222, 1'b0);
    plain("R2", 32'd63, 32'd0, 0, 0, 0, 0, 1'b0);
    plain("R5", 32'd51, 32'd0, 32'h920, 0, 0, 0, 1'b1);
    plain("R5", 32'd6, 32'h80FF_FFF1, 32'h920, 0, 0, 0, 1'b1);
    plain("R5", 32'd6, 32'h00FF_FFF1, 32'h920, 0, 0, 0, 1'b1);
    plain("R5", 32'd6, 32'h0000_0005, 32'h920, 0, 0, 0, 1'b0);

    xfer("R7", 6'd17, 32'h1400, 1'b0, 5'd9, 32'd4, 32'h8000_0000, 1, 32'd10, 1'b0, 1'b0);
    xfer("R6", 6'd18, 32'd100, 1'b1, 5'd9, 32'd3, 32'h0010_0000, 3, 32'd100, 1'b0, 1'b1);
    chk("R9", "start during busy ignored", resp_word0, 32'h900);
    chk("R10", "high-cap offset not flagged", {31'd0, misalign}, 32'd0);
    xfer("R6", 6'd25, 32'h2000, 1'b0, 5'd10, 32'd2, 32'h0000_4000, 2, 32'd8, 1'b1, 1'b0);
    xfer("R7", 6'd24, 32'h0, 1'b0, 5'd9, 32'd5, 32'h0000_0200, 1, 32'd0, 1'b1, 1'b0);
    xfer("R7", 6'd18, 32'h0, 1'b1, 5'd9, 32'd0, 32'h0, 0, 32'd0, 1'b0, 1'b0);
    chk("R10", "aligned offsets not flagged", {31'd0, misalign}, 32'd0);
    xfer("R10", 6'd17, 32'h1234, 1'b0, 5'd9, 32'd1, 32'h0000_1000, 1, 32'd9, 1'b0, 1'b0);
    chk("R10", "unaligned offset flagged", {31'd0, misalign}, 32'd1);
    plain("R10", 32'd13, 32'd0, 32'h900, 0, 0, 0, 1'b0);
    chk("R10", "flag stays set", {31'd0, misalign}, 32'd1);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule